// File: doc/BRIEF.md
# Registered-Input Single-Port RAM

This block is a small random access memory of 32 words, 4 bits each, reached through one shared address that serves both reading and writing. On every rising clock edge the address, the write word and the write strobe are taken into input registers. A write is then carried out from those registered copies on the following edge. The read port has no output register: it continuously presents the stored word at the registered address. This gives the block the port timing of an on-chip block-RAM primitive with registered inputs and an unregistered output.

The storage is a plain array of words with no reset. Synthesis can therefore map it onto dedicated memory blocks rather than onto flip-flops. The reset affects only the input registers. A host drives the address, data and strobe ahead of an edge and reads the word one edge later. A written value becomes visible two edges after it was presented.

Top module: `regin_ram`

## Requirements
- R1: The memory holds 2^AW words of DW bits (defaults AW=5, DW=4, so 32 words of 4 bits), selected by a single AW-bit address that is shared by reads and writes.
- R2: Address, write word and write strobe are sampled only at the rising clock edge. An input change between two edges has no effect on the output or on the memory until the next edge.
- R3: A write presented before edge k (strobe high) is committed at edge k+1. At that edge the word at the registered address is replaced by the registered data. Before edge k+1 the old word is still read.
- R4: `rdata_o` is combinational from the array at the registered address. After a commit to the registered address, the new word appears with no further edge.
- R5: Synchronous active-high reset sets the registered address to 0 and the registered strobe and data to 0. While reset is held, `rdata_o` shows word 0.
- R6: Reset leaves the stored words unchanged. A write strobe presented while reset is high is discarded.
- R7: With the strobe low, no stored word changes, whatever the address and data inputs carry.
- R8: When a commit and a change of registered address fall on the same edge, the word is written at the old registered address, and `rdata_o` shows the word at the new address.
- R9: Each of the 32 locations can be written and read back independently of every other location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset of the input registers |
| addr_i | input | AW (5) | Shared read/write word address |
| wdata_i | input | DW (4) | Word to be written |
| wen_i | input | 1 | Write strobe, high to write |
| rdata_o | output | DW (4) | Word stored at the registered address, unregistered |

## Verification
The write commit of one access and the address capture of the next access land on the same edge. The bench provokes this by presenting a write and, one cycle later, a read of another location. It then expects the output to show the new location's old word while the earlier location holds the written value. The second overlap is a commit to the very address being read. The bench samples once before the commit edge, where the old word is expected, and once after it, where the new word must appear without another edge. A shadow model kept by the bench supplies every expected word.

// File: rtl/regin_ram_pkg.sv
package regin_ram_pkg;
  parameter int RAM_AW = 5;
  parameter int RAM_DW = 4;
endpackage

// File: rtl/regin_ram_inreg.sv
module regin_ram_inreg #(
  parameter int AW = regin_ram_pkg::RAM_AW,
  parameter int DW = regin_ram_pkg::RAM_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wen_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wen_q
);
  // Input capture stage: every request pin passes through one register.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wen_q   <= 1'b0;
    end else begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wen_q   <= wen_i;
    end
  end

  // R5: reset leaves address zero and strobe low
  assert_rst_clear_R5: assert property (@(posedge clk) rst |=> (addr_q == '0 && !wen_q));

  // R2: registered copy equals the pins seen at the previous edge
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_q == $past(addr_i) && wdata_q == $past(wdata_i) && wen_q == $past(wen_i)));
endmodule

// File: rtl/regin_ram_store.sv
module regin_ram_store #(
  parameter int AW = regin_ram_pkg::RAM_AW,
  parameter int DW = regin_ram_pkg::RAM_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] wr_word,
  input  logic          wr_en,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  // Plain word array, no reset, so it can land in block memory.
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[acc_addr] <= wr_word;
  end

  assign rd_word = cells[acc_addr];

  // R3: a committed write is found at the address it targeted
  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cells[$past(acc_addr)] == $past(wr_word)));

  // R6: the reset input is seen here only by the checks above
  assert_rst_known_R6: assert property (@(posedge clk) !$isunknown(rst));
endmodule

// File: rtl/regin_ram.sv
module regin_ram #(
  parameter int AW = regin_ram_pkg::RAM_AW,
  parameter int DW = regin_ram_pkg::RAM_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wen_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wen_q;

  regin_ram_inreg #(.AW(AW), .DW(DW)) u_inreg (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wen_i   (wen_i),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .wen_q   (wen_q)
  );

  regin_ram_store #(.AW(AW), .DW(DW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .acc_addr (addr_q),
    .wr_word  (wdata_q),
    .wr_en    (wen_q),
    .rd_word  (rdata_o)
  );

  // R8: a write to the addressed word is visible on the output after the commit edge
  assert_raw_visible_R8: assert property (@(posedge clk) disable iff (rst)
    (wen_q && addr_i == addr_q) |=> (rdata_o == $past(wdata_q)));
endmodule

// File: tb/sim_regin_ram.sv
`timescale 1ns/1ps
module sim_regin_ram;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          wen_i = 1'b0;
  logic [DW-1:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  regin_ram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
    .wen_i(wen_i), .rdata_o(rdata_o)
  );

  // Fields: strobe, address, write word, expected read word
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 5'd0,  4'h5, 4'h5},
    {1'b1, 5'd31, 4'hA, 4'hA},
    {1'b0, 5'd0,  4'hF, 4'h5},
    {1'b0, 5'd31, 4'h0, 4'hA},
    {1'b1, 5'd16, 4'h3, 4'h3},
    {1'b1, 5'd16, 4'hC, 4'hC},
    {1'b0, 5'd16, 4'h7, 4'hC},
    {1'b0, 5'd0,  4'h9, 4'h5}
  };

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 11 + 6) & 15);
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic read_at(int a, string req);
    @(negedge clk);
    addr_i = AW'(a); wen_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, rdata_o, model[a]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 / R1: fill all 32 words back to back
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr_i = AW'(a); wdata_i = pat(a); wen_i = 1'b1;
      model[a] = pat(a);
    end
    @(negedge clk) wen_i = 1'b0;
    @(posedge clk);
    for (int a = 0; a < DEPTH; a++) read_at(a, "R9");

    // R5 / R6: reset with a write pending on the pins
    @(negedge clk);
    rst = 1'b1; addr_i = 5'd20; wdata_i = 4'hF; wen_i = 1'b1;
    @(posedge clk);
    @(negedge clk) check("R5", rdata_o, model[0]);
    @(posedge clk);
    @(negedge clk) check("R5", rdata_o, model[0]);
    wen_i = 1'b0; rst = 1'b0;
    @(posedge clk);
    @(negedge clk) check("R6", rdata_o, model[20]);

    // R3 / R4: latency of a write to the addressed word
    @(negedge clk);
    addr_i = 5'd7; wdata_i = 4'hE; wen_i = 1'b1;
    @(posedge clk);
    @(negedge clk) check("R3", rdata_o, model[7]);
    @(posedge clk);
    @(negedge clk) check("R4", rdata_o, 4'hE);
    model[7] = 4'hE; wen_i = 1'b0;
    @(posedge clk);

    // R8: commit and address move on one edge
    @(negedge clk);
    addr_i = 5'd9; wdata_i = 4'h1; wen_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addr_i = 5'd12; wdata_i = 4'h0; wen_i = 1'b0;
    @(posedge clk);
    @(negedge clk) check("R8", rdata_o, model[12]);
    model[9] = 4'h1;
    read_at(9, "R8");

    // R2: pins change between edges
    read_at(3, "R2");
    @(posedge clk);
    #1 addr_i = 5'd4; wdata_i = ~model[3]; wen_i = 1'b1;
    @(negedge clk) check("R2", rdata_o, model[3]);
    wen_i = 1'b0; addr_i = 5'd3;
    @(posedge clk);
    @(negedge clk) check("R2", rdata_o, model[3]);

    // R7: sweep with strobe low and inverted data
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr_i = AW'(a); wdata_i = ~model[a]; wen_i = 1'b0;
    end
    @(posedge clk);
    for (int a = 0; a < DEPTH; a++) read_at(a, "R7");

    // Vector table: R3, R4, R7
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wen_i = VEC[i][13]; addr_i = VEC[i][12:8]; wdata_i = VEC[i][7:4];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk) check(VEC[i][13] ? "R3" : "R7", rdata_o, VEC[i][3:0]);
    end
    @(negedge clk) wen_i = 1'b0;
    @(posedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule